// File: doc/BRIEF.md
# ADC Conversion Sequencer with Hardware Averaging

This block is the digital control core of a successive-approximation converter. Software writes a channel number into the channel register to start a conversion. The core then counts converter-clock ticks, derived from the bus clock by a selectable divider, through a fixed setup phase and one sampling window per averaged sample. While it counts, the external front end delivers digitized samples on a plain data port with a valid strobe.

At the end of each sampling window the core adds the most recently delivered sample to an accumulator. After the last window it divides the sum by the sample count, masks the result to the selected resolution and stores it in the result register. It then sets the done flag and, if enabled, raises the interrupt. In continuous mode the core restarts on the same channel after every completed result. Writing the disable code to the channel register aborts a conversion in progress.

The register port is a simple single-cycle write/read interface. Read data is combinational on the address, and a read strobe on the result address clears the done flag. Register map (address: fields):

- 0, channel: [4:0] channel, with 5'h1F meaning disabled; [7] interrupt enable.
- 1, status: [0] done flag; [1] busy.
- 2, result: the result, right-aligned.
- 3, config: [1:0] resolution; [3:2] divider; [5:4] sample-time select; [6] long-sample enable; [8:7] average count select; [9] overwrite enable.
- 4, general control: [0] averaging enable; [1] continuous mode.

Top module: `adc_seq_core`

## Requirements
- R1: Writing a channel number other than 5'h1F to address 0 starts a conversion on the next edge: busy (status bit 1 and `busy_o`) goes high, and `chan_o` shows the written channel.
- R2: The done flag becomes visible exactly D × (6 + N × (25 + S)) bus cycles after the start write edge. D is the divider, N the sample count and S the sample-time adder.
- R3: The sample-time adder S is 3, 5, 7 or 9 for select values 00/01/10/11 (config[5:4]) with config[6]=0, and 13, 17, 21 or 25 with config[6]=1.
- R4: With general control bit 0 clear, N is 1. With it set, config[8:7] values 00/01/10/11 give N = 4, 8, 16 or 32.
- R5: Config[3:2] values 00/01/10/11 give D = 1, 2, 4 or 8.
- R6: The result is the sum of the N samples taken at the end of each sampling window, shifted right by log2(N). Each window takes the last sample presented with `sample_valid_i`.
- R7: Config[1:0] selects the result width: 00 keeps the low 8 bits, 01 the low 10 bits, and 10 or 11 all 12 bits.
- R8: Status bit 0 is set when a result is stored and is cleared by a read strobe on address 2. After reset, status and result read 0 and the channel register reads 5'h1F.
- R9: `irq_o` is high exactly while the done flag and channel bit 7 are both set.
- R10: Writing 5'h1F to address 0 drops busy on the next edge and no result or flag follows.
- R11: With config[9]=0, a result that completes while the done flag is still set is discarded and the earlier result is kept. With config[9]=1, it replaces the earlier result.
- R12: With general control bit 1 set, each completion restarts the conversion on the same channel, so results repeat every D × (6 + N × (25 + S)) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (clears flag on result read) |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational on `addr_i` |
| sample_i | input | 12 | Digitized sample from the front end |
| sample_valid_i | input | 1 | Sample strobe |
| chan_o | output | 5 | Selected channel to the front end |
| busy_o | output | 1 | Conversion in progress |
| irq_o | output | 1 | Completion interrupt |

## Verification
The bench uses the default parameters: 12-bit samples, averaging up to 32 samples, a setup phase of 6 ticks and a base time of 25 ticks. With these values, every sample-time code, every averaging count and every divider setting has a latency short enough to measure edge-exactly against the formula, including the longest case of 32 samples. The 12-bit sample width lets one value show all three resolution masks. Changing the sample mid-conversion under 4-sample averaging shows the shift-based division at work.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned CFG_W  = 10;

  typedef enum logic [ADDR_W-1:0] {
    RA_CHAN = 3'd0,
    RA_STAT = 3'd1,
    RA_RES  = 3'd2,
    RA_CFG  = 3'd3,
    RA_GCTL = 3'd4
  } reg_addr_e;

  typedef struct packed {
    logic       ovw;
    logic [1:0] avg_sel;
    logic       long_smp;
    logic [1:0] sts;
    logic [1:0] div;
    logic [1:0] res;
  } cfg_t;

  function automatic logic [5:0] lst_cycles(input logic long_smp, input logic [1:0] sts);
    lst_cycles = long_smp ? (6'd13 + {2'b00, sts, 2'b00}) : (6'd3 + {3'b000, sts, 1'b0});
  endfunction

  function automatic logic [2:0] avg_log2(input logic en, input logic [1:0] sel);
    avg_log2 = en ? (3'd2 + {1'b0, sel}) : 3'd0;
  endfunction

endpackage

// File: rtl/adc_seq_clkdiv.sv
module adc_seq_clkdiv #(
  parameter int unsigned DIV_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             busy_i,
  input  logic [DIV_W-1:0] div_sel_i,
  output logic             tick_o
);
  localparam int unsigned CNT_W = (1 << DIV_W) - 1;

  logic [CNT_W-1:0] cnt_q, lim;

  assign lim    = CNT_W'((32'd1 << div_sel_i) - 32'd1);
  assign tick_o = busy_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (start_i || !busy_i) cnt_q <= '0;
    else if (cnt_q == lim)       cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  // R5: with a divider above one, ticks never come back to back
  a_r5_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_sel_i != '0 && !start_i) |=> !tick_o);

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int unsigned CNT_W     = 6,
  parameter int unsigned IDX_W     = 5,
  parameter int unsigned L2_W      = 3,
  parameter int unsigned SETUP_CYC = 6,
  parameter int unsigned BASE_CYC  = 25
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] lst_i,
  input  logic [L2_W-1:0]  avg_log2_i,
  output logic             busy_o,
  output logic             smp_end_o,
  output logic             last_o
);
  logic             busy_q, setup_q;
  logic [CNT_W-1:0] cnt_q, per_m1;
  logic [IDX_W-1:0] idx_q, n_last;

  assign per_m1    = CNT_W'(BASE_CYC - 1) + lst_i;
  assign n_last    = IDX_W'((32'd1 << avg_log2_i) - 32'd1);
  assign smp_end_o = tick_i && busy_q && !setup_q && (cnt_q == per_m1);
  assign last_o    = smp_end_o && (idx_q == n_last);
  assign busy_o    = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      setup_q <= 1'b0;
      cnt_q   <= '0;
      idx_q   <= '0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      setup_q <= 1'b1;
      cnt_q   <= '0;
      idx_q   <= '0;
    end else if (abort_i) begin
      busy_q  <= 1'b0;
    end else if (tick_i && busy_q) begin
      if (setup_q) begin
        if (cnt_q == CNT_W'(SETUP_CYC - 1)) begin
          setup_q <= 1'b0;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (smp_end_o) begin
        cnt_q <= '0;
        if (last_o) busy_q <= 1'b0;
        else        idx_q  <= idx_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !setup_q) |-> (cnt_q <= per_m1));

  a_r4_idx_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (idx_q <= n_last));

  a_r10_busy_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(last_o || abort_i));

endmodule

// File: rtl/adc_seq_avg.sv
module adc_seq_avg #(
  parameter int unsigned SMP_W        = 12,
  parameter int unsigned AVG_LOG2_MAX = 5,
  parameter int unsigned L2_W         = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SMP_W-1:0] sample_i,
  input  logic             sample_valid_i,
  input  logic             start_i,
  input  logic             smp_end_i,
  input  logic             last_i,
  input  logic [L2_W-1:0]  avg_log2_i,
  input  logic [1:0]       res_i,
  output logic [SMP_W-1:0] result_o
);
  localparam int unsigned ACC_W = SMP_W + AVG_LOG2_MAX;

  logic [SMP_W-1:0] smp_q, avg_w, mask;
  logic [ACC_W-1:0] acc_q, acc_nxt;
  logic [2:0]       drop;

  assign acc_nxt  = acc_q + ACC_W'(smp_q);
  assign avg_w    = SMP_W'(acc_nxt >> avg_log2_i);
  assign drop     = (res_i == 2'b00) ? 3'd4 : (res_i == 2'b01) ? 3'd2 : 3'd0;
  assign mask     = {SMP_W{1'b1}} >> drop;
  assign result_o = avg_w & mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             smp_q <= '0;
    else if (sample_valid_i) smp_q <= sample_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                acc_q <= '0;
    else if (start_i || last_i) acc_q <= '0;
    else if (smp_end_i)         acc_q <= acc_nxt;
  end

  // R6: the accumulator is empty after each completed average
  a_r6_acc_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_i |=> (acc_q == '0));

endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int unsigned SMP_W = 12,
  parameter int unsigned CH_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              busy_i,
  input  logic              conv_last_i,
  input  logic [SMP_W-1:0]  result_i,
  output cfg_t              cfg_o,
  output logic              avg_en_o,
  output logic              cont_o,
  output logic [CH_W-1:0]   chan_o,
  output logic              start_wr_o,
  output logic              abort_wr_o,
  output logic              irq_o
);
  localparam logic [CH_W-1:0] CH_OFF = '1;

  logic [CH_W-1:0]  ch_q;
  logic             ie_q, avg_en_q, cont_q, flag_q, take, rd_clear;
  cfg_t             cfg_q;
  logic [SMP_W-1:0] result_q;
  logic             wr_chan;

  assign wr_chan    = wr_en_i && (addr_i == RA_CHAN);
  assign start_wr_o = wr_chan && (wdata_i[CH_W-1:0] != CH_OFF);
  assign abort_wr_o = wr_chan && (wdata_i[CH_W-1:0] == CH_OFF);
  assign take       = conv_last_i && (cfg_q.ovw || !flag_q);
  assign rd_clear   = rd_en_i && (addr_i == RA_RES);
  assign irq_o      = flag_q && ie_q;
  assign cfg_o      = cfg_q;
  assign avg_en_o   = avg_en_q;
  assign cont_o     = cont_q;
  assign chan_o     = ch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch_q     <= CH_OFF;
      ie_q     <= 1'b0;
      cfg_q    <= '0;
      avg_en_q <= 1'b0;
      cont_q   <= 1'b0;
    end else if (wr_en_i) begin
      unique case (addr_i)
        RA_CHAN: begin
          ch_q <= wdata_i[CH_W-1:0];
          ie_q <= wdata_i[7];
        end
        RA_CFG:  cfg_q <= cfg_t'(wdata_i[CFG_W-1:0]);
        RA_GCTL: begin
          avg_en_q <= wdata_i[0];
          cont_q   <= wdata_i[1];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q   <= 1'b0;
      result_q <= '0;
    end else if (take) begin
      flag_q   <= 1'b1;
      result_q <= result_i;
    end else if (rd_clear) begin
      flag_q   <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      RA_CHAN: begin
        rdata_o[CH_W-1:0] = ch_q;
        rdata_o[7]        = ie_q;
      end
      RA_STAT: rdata_o[1:0]       = {busy_i, flag_q};
      RA_RES:  rdata_o[SMP_W-1:0] = result_q;
      RA_CFG:  rdata_o[CFG_W-1:0] = cfg_q;
      RA_GCTL: rdata_o[1:0]       = {cont_q, avg_en_q};
      default: rdata_o = '0;
    endcase
  end

  a_r8_flag_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(conv_last_i));

  a_r9_irq_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clear && !conv_last_i) |=> !irq_o);

  a_r11_keep_unread: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_last_i && !cfg_q.ovw && flag_q) |=> $stable(result_q));

endmodule

// File: rtl/adc_seq_core.sv
module adc_seq_core
  import adc_seq_pkg::*;
#(
  parameter int unsigned SMP_W        = 12,
  parameter int unsigned CH_W         = 5,
  parameter int unsigned AVG_LOG2_MAX = 5,
  parameter int unsigned SETUP_CYC    = 6,
  parameter int unsigned BASE_CYC     = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [SMP_W-1:0]  sample_i,
  input  logic              sample_valid_i,
  output logic [CH_W-1:0]   chan_o,
  output logic              busy_o,
  output logic              irq_o
);
  localparam int unsigned CNT_W = $clog2(BASE_CYC + 26);
  localparam int unsigned L2_W  = $clog2(AVG_LOG2_MAX + 1);
  localparam int unsigned IDX_W = AVG_LOG2_MAX;

  cfg_t             cfg;
  logic             avg_en, cont, start_wr, abort_wr, start, tick, smp_end, last, busy;
  logic [SMP_W-1:0] result;
  logic [CNT_W-1:0] lst_q;
  logic [L2_W-1:0]  l2_q;
  logic [1:0]       div_q, res_q;

  assign start  = start_wr || (last && cont && !abort_wr);
  assign busy_o = busy;

  // settings are frozen for the length of one conversion
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lst_q <= '0;
      l2_q  <= '0;
      div_q <= '0;
      res_q <= '0;
    end else if (start) begin
      lst_q <= CNT_W'(lst_cycles(cfg.long_smp, cfg.sts));
      l2_q  <= L2_W'(avg_log2(avg_en, cfg.avg_sel));
      div_q <= cfg.div;
      res_q <= cfg.res;
    end
  end

  adc_seq_regs #(.SMP_W(SMP_W), .CH_W(CH_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i, .rdata_o,
    .busy_i(busy), .conv_last_i(last), .result_i(result),
    .cfg_o(cfg), .avg_en_o(avg_en), .cont_o(cont), .chan_o(chan_o),
    .start_wr_o(start_wr), .abort_wr_o(abort_wr), .irq_o(irq_o)
  );

  adc_seq_clkdiv #(.DIV_W(2)) u_clkdiv (
    .clk_i, .rst_ni, .start_i(start), .busy_i(busy), .div_sel_i(div_q), .tick_o(tick)
  );

  adc_seq_timer #(
    .CNT_W(CNT_W), .IDX_W(IDX_W), .L2_W(L2_W),
    .SETUP_CYC(SETUP_CYC), .BASE_CYC(BASE_CYC)
  ) u_timer (
    .clk_i, .rst_ni, .start_i(start), .abort_i(abort_wr), .tick_i(tick),
    .lst_i(lst_q), .avg_log2_i(l2_q), .busy_o(busy), .smp_end_o(smp_end), .last_o(last)
  );

  adc_seq_avg #(.SMP_W(SMP_W), .AVG_LOG2_MAX(AVG_LOG2_MAX), .L2_W(L2_W)) u_avg (
    .clk_i, .rst_ni, .sample_i, .sample_valid_i, .start_i(start),
    .smp_end_i(smp_end), .last_i(last), .avg_log2_i(l2_q), .res_i(res_q), .result_o(result)
  );

  // R1: an accepted start write makes the core busy on the next edge
  a_r1_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_wr |=> busy_o);

  // R12: continuous mode never lets busy drop at completion
  a_r12_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && cont && !abort_wr) |=> busy_o);

endmodule

// File: tb/adc_seq_core_bench.sv
module adc_seq_core_bench;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0, sample_valid_i = 1'b0;
  logic [2:0]  addr_i = 3'd1;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic [11:0] sample_i = '0;
  logic [4:0]  chan_o;
  logic        busy_o, irq_o;

  int n_chk = 0, n_fail = 0, cyc = 0;

  adc_seq_core u_adc_seq_core (.*);

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) cyc++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk_i); wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i); wr_en_i = 1'b0; addr_i = 3'd1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk_i); rd_en_i = 1'b1; addr_i = a; #1 d = rdata_o;
    @(negedge clk_i); rd_en_i = 1'b0; addr_i = 3'd1;
  endtask

  task automatic load_sample(input logic [11:0] v);
    @(negedge clk_i); sample_i = v; sample_valid_i = 1'b1;
    @(negedge clk_i); sample_valid_i = 1'b0;
  endtask

  function automatic logic [15:0] mk_cfg(input bit ovw, input int avs, input bit lng,
                                         input int sts, input int dv, input int res);
    mk_cfg = {6'd0, ovw, 2'(avs), lng, 2'(sts), 2'(dv), 2'(res)};
  endfunction

  function automatic int exp_lat(input int d, input int n, input int s);
    exp_lat = d * (6 + n * (25 + s));
  endfunction

  // counts negedges after the start write until status bit 0 is seen high
  task automatic wait_flag(output int n);
    n = 0;
    addr_i = 3'd1;
    do begin @(negedge clk_i); n++; end while (!rdata_o[0] && n < 20000);
  endtask

  task automatic conv_lat(input logic [15:0] cfg, input bit aen, input int n, input int s,
                          input int d, input string req);
    int got; logic [15:0] r;
    wr(3'd3, cfg);
    wr(3'd4, {15'd0, aen});
    @(negedge clk_i); wr_en_i = 1'b1; addr_i = 3'd0; wdata_i = 16'd2;
    @(negedge clk_i); wr_en_i = 1'b0;
    wait_flag(got);
    chk(got == exp_lat(d, n, s), req, got, exp_lat(d, n, s));
    rd(3'd2, r);
  endtask

  task automatic t_reset;
    logic [15:0] r;
    rd(3'd1, r); chk(r == 16'd0, "R8 reset status", r, 0);
    rd(3'd2, r); chk(r == 16'd0, "R8 reset result", r, 0);
    rd(3'd0, r); chk(r == 16'h001F, "R8 reset channel", r, 31);
    chk(!busy_o && !irq_o, "R8 reset busy/irq", busy_o, 0);
  endtask

  task automatic t_lst_sweep;
    int lst [8] = '{3, 5, 7, 9, 13, 17, 21, 25};
    load_sample(12'h123);
    for (int i = 0; i < 8; i++)
      conv_lat(mk_cfg(1, 0, i[2], i % 4, 0, 2), 0, 1, lst[i], 1, "R2 R3 latency per adder");
  endtask

  task automatic t_avg_sweep;
    for (int i = 0; i < 4; i++)
      conv_lat(mk_cfg(1, i, 0, 0, 0, 2), 1, 4 << i, 3, 1, "R4 latency per average count");
  endtask

  task automatic t_div_sweep;
    for (int i = 1; i < 4; i++)
      conv_lat(mk_cfg(1, 0, 1, 1, i, 2), 0, 1, 17, 1 << i, "R5 latency per divider");
  endtask

  task automatic t_start_irq;
    int got; logic [15:0] r;
    load_sample(12'h5A5);
    wr(3'd3, mk_cfg(1, 0, 0, 0, 0, 2));
    wr(3'd4, 16'd0);
    wr(3'd0, 16'h0089);
    chk(busy_o == 1'b1, "R1 busy after start", busy_o, 1);
    chk(chan_o == 5'd9, "R1 channel out", chan_o, 9);
    chk(irq_o == 1'b0, "R9 irq low while converting", irq_o, 0);
    wait_flag(got);
    chk(irq_o == 1'b1, "R9 irq with flag and enable", irq_o, 1);
    rd(3'd2, r);
    chk(r == 16'h5A5, "R6 single sample result", r, 16'h5A5);
    #1 chk(irq_o == 1'b0, "R9 irq cleared by result read", irq_o, 0);
    rd(3'd1, r);
    chk(r[0] == 1'b0, "R8 flag cleared by result read", r[0], 0);
  endtask

  task automatic t_avg_value;
    int got; logic [15:0] r;
    load_sample(12'd100);
    wr(3'd3, mk_cfg(1, 0, 0, 0, 0, 2));
    wr(3'd4, 16'd1);
    wr(3'd0, 16'd4);
    // first window closes 34 edges after start; later windows see the new value
    repeat (38) @(negedge clk_i);
    sample_i = 12'd203; sample_valid_i = 1'b1;
    @(negedge clk_i); sample_valid_i = 1'b0;
    do @(negedge clk_i); while (!rdata_o[0]);
    rd(3'd2, r);
    chk(r == 16'd177, "R6 average of 100,203,203,203", r, 177);
    wr(3'd4, 16'd0);
  endtask

  task automatic t_res;
    int got; logic [15:0] r;
    int exp [3] = '{'h0BC, 'h2BC, 'hABC};
    load_sample(12'hABC);
    for (int i = 0; i < 3; i++) begin
      wr(3'd3, mk_cfg(1, 0, 0, 0, 0, i));
      wr(3'd0, 16'd1);
      wait_flag(got);
      rd(3'd2, r);
      chk(r == 16'(exp[i]), "R7 resolution mask", r, exp[i]);
    end
  endtask

  task automatic t_abort;
    logic [15:0] r;
    wr(3'd3, mk_cfg(1, 0, 0, 0, 0, 2));
    wr(3'd0, 16'd3);
    repeat (10) @(negedge clk_i);
    wr(3'd0, 16'h001F);
    chk(busy_o == 1'b0, "R10 busy drops on abort", busy_o, 0);
    repeat (60) @(negedge clk_i);
    rd(3'd1, r);
    chk(r[0] == 1'b0, "R10 no flag after abort", r[0], 0);
  endtask

  task automatic t_overwrite;
    int got; logic [15:0] r;
    load_sample(12'h111);
    wr(3'd3, mk_cfg(0, 0, 0, 0, 0, 2));
    wr(3'd0, 16'd1);
    wait_flag(got);
    load_sample(12'h222);
    wr(3'd0, 16'd1);
    repeat (40) @(negedge clk_i);
    rd(3'd2, r);
    chk(r == 16'h111, "R11 unread result kept", r, 16'h111);
    load_sample(12'h333);
    wr(3'd3, mk_cfg(1, 0, 0, 0, 0, 2));
    wr(3'd0, 16'd1);
    wait_flag(got);
    load_sample(12'h444);
    wr(3'd0, 16'd1);
    repeat (40) @(negedge clk_i);
    rd(3'd2, r);
    chk(r == 16'h444, "R11 overwrite enabled replaces", r, 16'h444);
  endtask

  task automatic t_cont;
    int c0, c1, got; logic [15:0] r;
    wr(3'd3, mk_cfg(1, 0, 0, 0, 0, 2));
    wr(3'd4, 16'd2);
    wr(3'd0, 16'd5);
    wait_flag(got);
    c0 = cyc;
    rd(3'd2, r);
    wait_flag(got);
    c1 = cyc;
    chk(c1 - c0 == 34, "R12 continuous period", c1 - c0, 34);
    chk(busy_o == 1'b1 && chan_o == 5'd5, "R12 restart on same channel", chan_o, 5);
    wr(3'd4, 16'd0);
    wr(3'd0, 16'h001F);
    rd(3'd2, r);
    #1 chk(busy_o == 1'b0, "R12 stops after abort", busy_o, 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_lst_sweep();
    t_avg_sweep();
    t_div_sweep();
    t_start_irq();
    t_avg_value();
    t_res();
    t_abort();
    t_overwrite();
    t_cont();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule